// File: doc/BRIEF.md
# Reloading Range Counter and Frequency Divider

This block is a cascade of 4-bit binary counter slices (two by default, giving an 8-bit count) that can run through a chosen range of values, repeat it, and so divide the clock. Each slice has an active-low asynchronous clear, an active-low synchronous load of a start value and a count enable. Each slice also flags when it holds all ones, and the next slice up uses that flag as its carry.

Decode logic around the counter closes the loop in one of four modes. In mode 0 it decodes the bits that are set in `end_i` and drives the synchronous load. In mode 1 the all-ones carry of the whole cascade drives the load. In mode 2 the decoded end value drives the asynchronous clear. Mode 3 runs the counter freely. `reload_o` marks the last cycle of every period, so it pulses once per period. Each bit k of `count_o` is a divided clock with a period of 2^(k+1) cycles when the counter runs freely.

Top module: `range_divider`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 at once, without waiting for a clock edge.
- R2: In a reload cycle of mode 0 or mode 1, the next rising edge loads `start_i`, even when `cnt_en_i` is low.
- R3: Outside a reload, `count_o` rises by 1 (modulo 2^8) on each edge while `cnt_en_i` is high, and holds while it is low.
- R4: `carry_o` is high exactly when `count_o` is 255.
- R5: The upper slice advances only on edges where the lower slice holds 15 and `cnt_en_i` is high. The two slices together count 0 to 255 and wrap to 0.
- R6: Mode 0 (`mode_i`=0) is reload on match. A cycle whose count has every bit that is set in `end_i` also set is a reload cycle, and `reload_o` is high in it. With start 3 and end 7 the sequence is 3,4,5,6,7,3. With start 5 and end 24 the range spans both slices and covers 5 to 24.
- R7: Mode 1 (`mode_i`=1) is reload on carry. The cycle at 255 is a reload cycle and `reload_o` is high in it. Start 251 gives 251 to 255 and then 251 again.
- R8: Mode 2 (`mode_i`=2) is clear on match. When the count reaches a value that holds all the set bits of `end_i`, the asynchronous clear drives it to 0 within the same cycle. End 5 gives the observed values 0 to 4. `reload_o` is high in any cycle where `cnt_en_i` is high and count+1 holds all those bits.
- R9: Mode 3 (`mode_i`=3) is free running. `reload_o` stays low, and bit k of `count_o` has a period of 2^(k+1) clocks.
- R10: With start 3 and end 7 in mode 0, the circuit divides by 5. `reload_o` pulses once every 5 clocks and `count_o[2]` repeats every 5 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous clear, active low |
| cnt_en_i | input | 1 | Count enable |
| mode_i | input | 2 | 0 reload on match, 1 reload on carry, 2 clear on match, 3 free run |
| start_i | input | 8 | Value loaded on reload |
| end_i | input | 8 | Decoded end value (bits that must all be set) |
| count_o | output | 8 | Count; each bit is a clock tap |
| carry_o | output | 1 | High when the count is all ones |
| reload_o | output | 1 | High in the last cycle of each period |

## Verification
The assertions take three things for granted. First, `mode_i`, `start_i` and `end_i` change only while `rst_ni` is low. Second, in the match modes `start_i` does not exceed `end_i`, so the partial decode hits the end value itself and not some larger value. Third, in clear mode `end_i` is nonzero. The stimulus respects all three: every configuration is applied inside a reset pulse and released at a falling edge, and only `cnt_en_i` is toggled while the counter runs. The toggles of `cnt_en_i` happen on falling edges, and one of them lands in a reload cycle to show that the load overrides the enable.

// File: rtl/range_div_pkg.sv
package range_div_pkg;
  typedef enum logic [1:0] {
    MODE_MATCH_LOAD  = 2'd0,
    MODE_CARRY_LOAD  = 2'd1,
    MODE_MATCH_CLEAR = 2'd2,
    MODE_FREE        = 2'd3
  } mode_e;
endpackage

// File: rtl/cnt_slice.sv
module cnt_slice #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic             tc_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni)      q_q <= '0;
    else if (!load_ni) q_q <= d_i;
    else if (en_i)    q_q <= q_q + WIDTH'(1);
  end

  assign q_o  = q_q;
  assign tc_o = &q_q;

  a_r2_load_takes_data: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !load_ni |=> q_o == $past(d_i));

  // a clear from the decode may still zero an idle slice
  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (load_ni && !en_i) |=> ($stable(q_o) || q_o == '0));
endmodule

// File: rtl/bit_match.sv
module bit_match #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             hit_o
);
  // hit when every bit set in mask_i is also set in val_i
  assign hit_o = &(val_i | ~mask_i);
endmodule

// File: rtl/range_divider.sv
module range_divider
  import range_div_pkg::*;
#(
  parameter int unsigned SLICES  = 2,
  parameter int unsigned SLICE_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cnt_en_i,
  input  logic [1:0]                 mode_i,
  input  logic [SLICES*SLICE_W-1:0]  start_i,
  input  logic [SLICES*SLICE_W-1:0]  end_i,
  output logic [SLICES*SLICE_W-1:0]  count_o,
  output logic                       carry_o,
  output logic                       reload_o
);
  localparam int unsigned CNT_W = SLICES * SLICE_W;

  mode_e             mode;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_inc;
  logic [SLICES:0]   en_chain;
  logic [SLICES-1:0] tc;
  logic              hit_now;
  logic              hit_next;
  logic              load_req;
  logic              clr_n;

  assign mode        = mode_e'(mode_i);
  assign en_chain[0] = cnt_en_i;
  assign cnt_inc     = cnt + CNT_W'(1);

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    assign en_chain[s+1] = en_chain[s] & tc[s];
    cnt_slice #(.WIDTH(SLICE_W)) i_slice (
      .clk_i   (clk_i),
      .clr_ni  (clr_n),
      .load_ni (~load_req),
      .en_i    (en_chain[s]),
      .d_i     (start_i[s*SLICE_W +: SLICE_W]),
      .q_o     (cnt[s*SLICE_W +: SLICE_W]),
      .tc_o    (tc[s])
    );
  end

  bit_match #(.WIDTH(CNT_W)) i_match_now (
    .val_i (cnt), .mask_i (end_i), .hit_o (hit_now)
  );
  bit_match #(.WIDTH(CNT_W)) i_match_next (
    .val_i (cnt_inc), .mask_i (end_i), .hit_o (hit_next)
  );

  always_comb begin
    unique case (mode)
      MODE_MATCH_LOAD: load_req = hit_now;
      MODE_CARRY_LOAD: load_req = &tc;
      default:         load_req = 1'b0;
    endcase
  end

  // clear-on-match feeds the decoded value straight into the async clear
  assign clr_n    = rst_ni & ~((mode == MODE_MATCH_CLEAR) & hit_now);
  assign reload_o = (mode == MODE_MATCH_CLEAR) ? (cnt_en_i & hit_next) : load_req;
  assign carry_o  = &tc;
  assign count_o  = cnt;

  a_r6_match_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MATCH_LOAD && reload_o) |=> count_o == $past(start_i));

  a_r7_carry_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CARRY_LOAD && carry_o) |=> count_o == $past(start_i));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_MATCH_CLEAR && !reload_o && cnt_en_i)
      |=> count_o == $past(count_o) + CNT_W'(1));

  a_r8_match_never_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MATCH_CLEAR && end_i != '0) |-> !hit_now);

  a_r9_free_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FREE) |-> !reload_o);
endmodule

// File: tb/test_range_divider.sv
module test_range_divider;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] cnt;
    logic       rel;
    logic       cy;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] start_v = '0;
  logic [7:0] end_v = '0;
  logic [7:0] count;
  logic       carry;
  logic       reload;

  int checks = 0;
  int errors = 0;
  int rel_seen = 0;
  string cur_tag = "";
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  range_divider i_range_divider (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .cnt_en_i (en),
    .mode_i   (mode),
    .start_i  (start_v),
    .end_i    (end_v),
    .count_o  (count),
    .carry_o  (carry),
    .reload_o (reload)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] m, input logic e_in);
    logic [7:0] n;
    case (mode)
      2'd0: nxt = ((m & end_v) == end_v) ? start_v : (e_in ? m + 8'd1 : m);
      2'd1: nxt = (m == 8'hff) ? start_v : (e_in ? m + 8'd1 : m);
      2'd2: begin
        n = e_in ? m + 8'd1 : m;
        nxt = ((n & end_v) == end_v) ? 8'd0 : n;
      end
      default: nxt = e_in ? m + 8'd1 : m;
    endcase
  endfunction

  function automatic logic rel_of(input logic [7:0] m, input logic e_in);
    logic [7:0] n;
    n = m + 8'd1;
    case (mode)
      2'd0: rel_of = (m & end_v) == end_v;
      2'd1: rel_of = m == 8'hff;
      2'd2: rel_of = e_in && ((n & end_v) == end_v);
      default: rel_of = 1'b0;
    endcase
  endfunction

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(count == it.cnt, cur_tag, count, it.cnt);
      check(reload == it.rel, {cur_tag, " reload"}, reload, it.rel);
      check(carry == it.cy, "R4 carry", carry, it.cy);
      if (reload) rel_seen++;
    end
  end

  task automatic run(input logic [1:0] md, input logic [7:0] s, input logic [7:0] e,
                     input int n, input int off_at, input int off_len,
                     input int exp_rel, input string tag);
    logic [7:0] m;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(count == 8'd0, "R1 async clear", count, 0);
    mode = md; start_v = s; end_v = e; en = 1'b1;
    cur_tag = tag;
    @(negedge clk);
    rst_n = 1'b1;
    rel_seen = 0;
    m = 8'd0;
    for (int i = 0; i < n; i++) begin
      exp_t it;
      @(posedge clk);
      m = nxt(m, en);
      it.cnt = m; it.rel = rel_of(m, en); it.cy = (m == 8'hff);
      exp_q.push_back(it);
      if (i == off_at) begin @(negedge clk); en = 1'b0; end
      if (i == off_at + off_len) begin @(negedge clk); en = 1'b1; end
    end
    @(negedge clk);
    #1;
    if (exp_rel >= 0) check(rel_seen == exp_rel, {tag, " period"}, rel_seen, exp_rel);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R6 R10: start 3 end 7 -> 3..7, divide by 5
    run(2'd0, 8'd3, 8'd7, 40, -1, 0, 7, "R6 R10 divide-by-5");
    // R7: carry reload 251..255
    run(2'd1, 8'd251, 8'hff, 280, -1, 0, 6, "R7 carry reload");
    // R8: clear on 5 -> 0..4
    run(2'd2, 8'd0, 8'd5, 23, -1, 0, 4, "R8 clear on match");
    // R3 R5 R9: free run, enable off at 15 across the slice boundary
    run(2'd3, 8'd0, 8'd0, 300, 14, 4, 0, "R3 R5 R9 free run");
    // R2: enable dropped in the reload cycle, load still happens
    run(2'd0, 8'd3, 8'd7, 20, 6, 6, -1, "R2 load overrides enable");
    // R5 R6: cascaded range 5..24
    run(2'd0, 8'd5, 8'd24, 60, -1, 0, -1, "R5 R6 wide range");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule